// File: doc/BRIEF.md
# DDR4 Command and Address Decoder

This block watches the command and address inputs of a DDR4 device and turns each rising-clock sample into a single decoded command. It handles activate, read, write, single-bank and all-bank precharge, mode-register set, refresh, no-operation and deselect. Along with the command code it returns only the fields that command carries: bank group, bank, row or column address, the auto-precharge and burst-chop flags, the mode-register number and its opcode, and the stacked-die chip ID.

One shared 18-bit address bus feeds the block. Bits 16, 15 and 14 of that bus are also the row-strobe, column-strobe and write-enable command pins. The activate-select input decides which of the two roles they take in a given cycle. Every result is registered and comes out one clock after the edge that sampled it, marked by a one-cycle valid strobe. Fields that the decoded command does not use are forced to zero, so logic further down can take them without first checking the command code.

Top module: `cmd_dec_top`

## Requirements
- R1: Inputs are captured only on the rising clock edge. The decoded result is on the outputs for the cycle that follows that edge, and `cmdValid` is high for that one cycle for every sample taken with `csN` low.
- R2: A sample with `csN` high gives `cmdValid` = 0, `cmdCode` = 0 (deselect), and all field outputs, `chipIdOut` included, at zero.
- R3: With `csN` and `actN` both low the command is activate, `cmdCode` = 2. `rowAddr` takes all 18 bus bits, bits 16..14 included, and `bankGroup` and `bank` take `bg` and `ba`.
- R4: With `csN` low and `actN` high, bus bits {16,15,14} are the command pins. 000 gives mode-register set (code 6), 001 refresh (code 7), 010 precharge (code 5), 100 write (code 4), 101 read (code 3) and 111 no-operation (code 1).
- R5: For a read or write, `colAddr` is bus bits 9..0, and `bankGroup` and `bank` take `bg` and `ba`. Bus bits 10 and 12 never reach `colAddr`.
- R6: For a read or write, `autoPre` equals bus bit 10.
- R7: For a read or write, `burstChop` is 1 when bus bit 12 is low and 0 when it is high.
- R8: For a precharge with bus bit 10 low, `preAll` = 0 and the target bank is given on `bankGroup` and `bank`. With bit 10 high, `preAll` = 1 and both bank outputs are zero.
- R9: For a mode-register set, `mrSel` = {`bg`,`ba`} and `mrOpcode` is bus bits 13..0.
- R10: Every valid command passes the sampled `chipId` to `chipIdOut`.
- R11: Any field the decoded command does not carry is output as zero. Refresh and no-operation carry only the code and the chip ID, and activate leaves `colAddr` and both flags at zero.
- R12: While `rstN` is low, `cmdValid` is 0, `cmdCode` is 0 and every field is zero.
- R13: The command-pin encodings 011 and 110 decode as no-operation (code 1) with `cmdValid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| actN | input | 1 | Activate select, active low |
| addrBus | input | 18 | Shared address bus; bits 16/15/14 double as the command pins |
| bg | input | 2 | Bank group address |
| ba | input | 2 | Bank address |
| chipId | input | 3 | Stacked-die chip ID |
| cmdValid | output | 1 | One-cycle strobe for a decoded command |
| cmdCode | output | 3 | Decoded command code (see R4) |
| bankGroup | output | 2 | Bank group of the command |
| bank | output | 2 | Bank of the command |
| rowAddr | output | 18 | Activate row address |
| colAddr | output | 10 | Read/write column address |
| autoPre | output | 1 | Auto precharge requested |
| burstChop | output | 1 | Burst chop requested |
| preAll | output | 1 | Precharge applies to all banks |
| mrSel | output | 4 | Mode register selected |
| mrOpcode | output | 14 | Mode-register opcode |
| chipIdOut | output | 3 | Chip ID of the command |

## Verification
Every result is due exactly one clock after the sampling edge, with no extra pipeline stage. Each scenario task drives its inputs on a falling edge, waits for the next rising edge, then waits one more time unit before it reads the outputs, so the sample is always taken after the single register stage has updated. A command placed just ahead of a deselect shows that the valid strobe drops one cycle later. The clocked properties use the same one-cycle relation, written with `|=>`.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  typedef enum logic [2:0] {
    CMD_DES = 3'd0,
    CMD_NOP = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_PRE = 3'd5,
    CMD_MRS = 3'd6,
    CMD_REF = 3'd7
  } cmdCode_e;

  // Load strobes from control to datapath
  typedef struct packed {
    logic     valid;
    cmdCode_e code;
    logic     ldBank;
    logic     ldRow;
    logic     ldCol;
    logic     ldFlags;
    logic     ldMr;
    logic     preAll;
  } ctrlStrobes_t;
endpackage

// File: rtl/cmd_dec_ctrl.sv
module cmd_dec_ctrl
  import cmd_dec_pkg::*;
(
  input  logic         csN,
  input  logic         actN,
  input  logic         rasPin,
  input  logic         casPin,
  input  logic         wePin,
  input  logic         apPin,
  output ctrlStrobes_t strobes
);
  logic [2:0] pinCode;
  assign pinCode = {rasPin, casPin, wePin};

  always_comb begin
    strobes = '0;
    strobes.code = CMD_DES;
    if (!csN) begin
      strobes.valid = 1'b1;
      if (!actN) begin
        strobes.code   = CMD_ACT;
        strobes.ldBank = 1'b1;
        strobes.ldRow  = 1'b1;
      end else begin
        unique case (pinCode)
          3'b000: begin
            strobes.code = CMD_MRS;
            strobes.ldMr = 1'b1;
          end
          3'b001: strobes.code = CMD_REF;
          3'b010: begin
            strobes.code   = CMD_PRE;
            strobes.preAll = apPin;
            strobes.ldBank = !apPin;
          end
          3'b100: begin
            strobes.code    = CMD_WR;
            strobes.ldBank  = 1'b1;
            strobes.ldCol   = 1'b1;
            strobes.ldFlags = 1'b1;
          end
          3'b101: begin
            strobes.code    = CMD_RD;
            strobes.ldBank  = 1'b1;
            strobes.ldCol   = 1'b1;
            strobes.ldFlags = 1'b1;
          end
          default: strobes.code = CMD_NOP;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_dec_dpath.sv
module cmd_dec_dpath
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int COL_W  = 10,
  parameter int OP_W   = 14,
  parameter int BG_W   = 2,
  parameter int BA_W   = 2,
  parameter int CID_W  = 3,
  parameter int AP_BIT = 10,
  parameter int BC_BIT = 12,
  localparam int MR_W  = BG_W + BA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic [BG_W-1:0]   bg,
  input  logic [BA_W-1:0]   ba,
  input  logic [CID_W-1:0]  chipId,
  output logic              cmdValid,
  output logic [2:0]        cmdCode,
  output logic [BG_W-1:0]   bankGroup,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [COL_W-1:0]  colAddr,
  output logic              autoPre,
  output logic              burstChop,
  output logic              preAll,
  output logic [MR_W-1:0]   mrSel,
  output logic [OP_W-1:0]   mrOpcode,
  output logic [CID_W-1:0]  chipIdOut
);
  logic              nValid, nAp, nBc, nPreAll;
  logic [2:0]        nCode;
  logic [BG_W-1:0]   nBg;
  logic [BA_W-1:0]   nBa;
  logic [ADDR_W-1:0] nRow;
  logic [COL_W-1:0]  nCol;
  logic [MR_W-1:0]   nMrSel;
  logic [OP_W-1:0]   nOp;
  logic [CID_W-1:0]  nCid;

  always_comb begin
    nValid  = strobes.valid;
    nCode   = strobes.code;
    nPreAll = strobes.preAll;
    nBg = '0; nBa = '0; nRow = '0; nCol = '0;
    nAp = 1'b0; nBc = 1'b0; nMrSel = '0; nOp = '0; nCid = '0;
    if (strobes.ldBank) begin
      nBg = bg;
      nBa = ba;
    end
    if (strobes.ldRow) nRow = addrBus;
    if (strobes.ldCol) nCol = addrBus[COL_W-1:0];
    if (strobes.ldFlags) begin
      nAp = addrBus[AP_BIT];
      nBc = !addrBus[BC_BIT];
    end
    if (strobes.ldMr) begin
      nMrSel = {bg, ba};
      nOp    = addrBus[OP_W-1:0];
    end
    if (strobes.valid) nCid = chipId;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      cmdCode   <= CMD_DES;
      bankGroup <= '0;
      bank      <= '0;
      rowAddr   <= '0;
      colAddr   <= '0;
      autoPre   <= 1'b0;
      burstChop <= 1'b0;
      preAll    <= 1'b0;
      mrSel     <= '0;
      mrOpcode  <= '0;
      chipIdOut <= '0;
    end else begin
      cmdValid  <= nValid;
      cmdCode   <= nCode;
      bankGroup <= nBg;
      bank      <= nBa;
      rowAddr   <= nRow;
      colAddr   <= nCol;
      autoPre   <= nAp;
      burstChop <= nBc;
      preAll    <= nPreAll;
      mrSel     <= nMrSel;
      mrOpcode  <= nOp;
      chipIdOut <= nCid;
    end
  end
endmodule

// File: rtl/cmd_dec_top.sv
module cmd_dec_top
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int COL_W   = 10,
  parameter int OP_W    = 14,
  parameter int BG_W    = 2,
  parameter int BA_W    = 2,
  parameter int CID_W   = 3,
  parameter int AP_BIT  = 10,
  parameter int BC_BIT  = 12,
  parameter int RAS_BIT = 16,
  parameter int CAS_BIT = 15,
  parameter int WE_BIT  = 14,
  localparam int MR_W   = BG_W + BA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              actN,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic [BG_W-1:0]   bg,
  input  logic [BA_W-1:0]   ba,
  input  logic [CID_W-1:0]  chipId,
  output logic              cmdValid,
  output logic [2:0]        cmdCode,
  output logic [BG_W-1:0]   bankGroup,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [COL_W-1:0]  colAddr,
  output logic              autoPre,
  output logic              burstChop,
  output logic              preAll,
  output logic [MR_W-1:0]   mrSel,
  output logic [OP_W-1:0]   mrOpcode,
  output logic [CID_W-1:0]  chipIdOut
);
  ctrlStrobes_t strobes;

  cmd_dec_ctrl uCtrl (
    .csN    (csN),
    .actN   (actN),
    .rasPin (addrBus[RAS_BIT]),
    .casPin (addrBus[CAS_BIT]),
    .wePin  (addrBus[WE_BIT]),
    .apPin  (addrBus[AP_BIT]),
    .strobes(strobes)
  );

  cmd_dec_dpath #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .OP_W(OP_W), .BG_W(BG_W),
    .BA_W(BA_W), .CID_W(CID_W), .AP_BIT(AP_BIT), .BC_BIT(BC_BIT)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addrBus  (addrBus),
    .bg       (bg),
    .ba       (ba),
    .chipId   (chipId),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .bankGroup(bankGroup),
    .bank     (bank),
    .rowAddr  (rowAddr),
    .colAddr  (colAddr),
    .autoPre  (autoPre),
    .burstChop(burstChop),
    .preAll   (preAll),
    .mrSel    (mrSel),
    .mrOpcode (mrOpcode),
    .chipIdOut(chipIdOut)
  );
endmodule

// File: rtl/cmd_dec_chk.sv
module cmd_dec_chk
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int COL_W  = 10,
  parameter int BG_W   = 2,
  parameter int BA_W   = 2,
  parameter int CID_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              actN,
  input logic [ADDR_W-1:0] addrBus,
  input logic [CID_W-1:0]  chipId,
  input logic              cmdValid,
  input logic [2:0]        cmdCode,
  input logic [BG_W-1:0]   bankGroup,
  input logic [BA_W-1:0]   bank,
  input logic [ADDR_W-1:0] rowAddr,
  input logic [COL_W-1:0]  colAddr,
  input logic              autoPre,
  input logic              burstChop,
  input logic              preAll,
  input logic [CID_W-1:0]  chipIdOut
);
  logic cmdPins, rdWr;
  assign cmdPins = !csN && actN;
  assign rdWr = cmdPins && addrBus[16] && !addrBus[15];

  // R1
  cycle_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> cmdValid);

  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!cmdValid && cmdCode == CMD_DES && rowAddr == '0 && chipIdOut == '0));

  // R3
  act_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !actN) |=> (cmdCode == CMD_ACT && rowAddr == $past(addrBus)));

  // R6
  auto_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdWr |=> (autoPre == $past(addrBus[10])));

  // R7
  burst_chop_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdWr |=> (burstChop != $past(addrBus[12])));

  // R8
  pre_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPins && addrBus[16:14] == 3'b010 && addrBus[10])
      |=> (preAll && bankGroup == '0 && bank == '0));

  // R10
  chip_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> (chipIdOut == $past(chipId)));

  // R11
  act_no_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_ACT) |-> (colAddr == '0 && !autoPre && !burstChop));
endmodule

bind cmd_dec_top cmd_dec_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .BG_W(BG_W), .BA_W(BA_W), .CID_W(CID_W)
) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .actN(actN), .addrBus(addrBus),
  .chipId(chipId), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .bankGroup(bankGroup), .bank(bank), .rowAddr(rowAddr), .colAddr(colAddr),
  .autoPre(autoPre), .burstChop(burstChop), .preAll(preAll),
  .chipIdOut(chipIdOut)
);

// File: tb/sim_cmd_dec_top.sv
module sim_cmd_dec_top;
  localparam int CLK_P = 10;
  localparam logic [2:0] C_DES = 3'd0, C_NOP = 3'd1, C_ACT = 3'd2, C_RD = 3'd3,
                         C_WR = 3'd4, C_PRE = 3'd5, C_MRS = 3'd6, C_REF = 3'd7;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, actN = 1'b1;
  logic [17:0] addrBus = '0;
  logic [1:0] bg = '0, ba = '0;
  logic [2:0] chipId = '0;
  logic cmdValid, autoPre, burstChop, preAll;
  logic [2:0] cmdCode, chipIdOut;
  logic [1:0] bankGroup, bank;
  logic [17:0] rowAddr;
  logic [9:0] colAddr;
  logic [3:0] mrSel;
  logic [13:0] mrOpcode;

  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  cmd_dec_top u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .actN(actN), .addrBus(addrBus),
    .bg(bg), .ba(ba), .chipId(chipId), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .bankGroup(bankGroup), .bank(bank), .rowAddr(rowAddr), .colAddr(colAddr),
    .autoPre(autoPre), .burstChop(burstChop), .preAll(preAll), .mrSel(mrSel),
    .mrOpcode(mrOpcode), .chipIdOut(chipIdOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] mkBus(input logic a17, input logic [2:0] pins,
                                        input logic [13:0] lo);
    return {a17, pins, lo};
  endfunction

  // Drive on a falling edge, then sample one time unit after the next rising edge
  task automatic drive(input logic cs, input logic act, input logic [17:0] bus,
                       input logic [1:0] g, input logic [1:0] b, input logic [2:0] c);
    @(negedge clk);
    csN = cs; actN = act; addrBus = bus; bg = g; ba = b; chipId = c;
    @(posedge clk);
    #1;
  endtask

  task automatic tReset();
    #1;
    chk("R12 valid", cmdValid, 0);
    chk("R12 code", cmdCode, C_DES);
    chk("R12 row", rowAddr, 0);
    chk("R12 mrOpcode", mrOpcode, 0);
  endtask

  task automatic tDeselect();
    drive(1'b1, 1'b0, 18'h3FFFF, 2'b11, 2'b11, 3'b111);
    chk("R2 valid", cmdValid, 0);
    chk("R2 code", cmdCode, C_DES);
    chk("R2 row", rowAddr, 0);
    chk("R2 chipId", chipIdOut, 0);
    chk("R2 bank", {bankGroup, bank}, 0);
  endtask

  task automatic tActivate(input logic [17:0] row, input logic [1:0] g,
                           input logic [1:0] b, input logic [2:0] c);
    drive(1'b0, 1'b0, row, g, b, c);
    chk("R1 valid", cmdValid, 1);
    chk("R3 code", cmdCode, C_ACT);
    chk("R3 row", rowAddr, row);
    chk("R3 bank", {bankGroup, bank}, {g, b});
    chk("R11 act col", {colAddr, autoPre, burstChop, mrOpcode}, 0);
    chk("R10 chipId", chipIdOut, c);
  endtask

  task automatic tRdWr(input logic isWr, input logic ap, input logic a12);
    logic [13:0] lo;
    lo = 14'h0000 | (14'(a12) << 12) | (14'(ap) << 10) | 14'h2A7 | 14'h0800;
    drive(1'b0, 1'b1, mkBus(1'b1, isWr ? 3'b100 : 3'b101, lo), 2'b10, 2'b01, 3'b011);
    chk("R4 rd/wr code", cmdCode, isWr ? C_WR : C_RD);
    chk("R5 col", colAddr, 10'h2A7);
    chk("R5 bank", {bankGroup, bank}, 4'b1001);
    chk("R6 autoPre", autoPre, ap);
    chk("R7 burstChop", burstChop, !a12);
    chk("R11 rd/wr row", rowAddr, 0);
  endtask

  task automatic tPrecharge(input logic ap);
    drive(1'b0, 1'b1, mkBus(1'b0, 3'b010, 14'(ap) << 10), 2'b01, 2'b11, 3'b101);
    chk("R4 pre code", cmdCode, C_PRE);
    chk("R8 preAll", preAll, ap);
    chk("R8 bank", {bankGroup, bank}, ap ? 4'b0000 : 4'b0111);
  endtask

  task automatic tMrs();
    drive(1'b0, 1'b1, mkBus(1'b1, 3'b000, 14'h1B3C), 2'b10, 2'b11, 3'b010);
    chk("R4 mrs code", cmdCode, C_MRS);
    chk("R9 mrSel", mrSel, 4'b1011);
    chk("R9 opcode", mrOpcode, 14'h1B3C);
    chk("R11 mrs bank", {bankGroup, bank, rowAddr}, 0);
  endtask

  task automatic tRefreshNop();
    drive(1'b0, 1'b1, mkBus(1'b1, 3'b001, 14'h3FFF), 2'b11, 2'b11, 3'b110);
    chk("R4 ref code", cmdCode, C_REF);
    chk("R11 ref fields", {bankGroup, bank, colAddr, autoPre, burstChop, preAll, mrSel}, 0);
    chk("R10 ref chipId", chipIdOut, 3'b110);
    drive(1'b0, 1'b1, mkBus(1'b0, 3'b111, 14'h1555), 2'b01, 2'b01, 3'b001);
    chk("R4 nop code", cmdCode, C_NOP);
    chk("R11 nop fields", {bankGroup, bank, colAddr, rowAddr, mrOpcode}, 0);
  endtask

  task automatic tOddEncodings();
    drive(1'b0, 1'b1, mkBus(1'b0, 3'b011, 14'h0400), 2'b00, 2'b00, 3'b000);
    chk("R13 011 code", cmdCode, C_NOP);
    chk("R13 011 valid", cmdValid, 1);
    drive(1'b0, 1'b1, mkBus(1'b0, 3'b110, 14'h0400), 2'b00, 2'b00, 3'b000);
    chk("R13 110 code", cmdCode, C_NOP);
  endtask

  task automatic tPulse();
    drive(1'b0, 1'b0, 18'h12345, 2'b01, 2'b10, 3'b100);
    chk("R1 pulse high", cmdValid, 1);
    drive(1'b1, 1'b1, 18'h0, 2'b00, 2'b00, 3'b000);
    chk("R1 pulse low", cmdValid, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    tDeselect();
    tActivate(18'h3FFFF, 2'b11, 2'b00, 3'b101);
    tActivate(18'h29C35, 2'b00, 2'b11, 3'b010);
    tRdWr(1'b0, 1'b1, 1'b0);
    tRdWr(1'b0, 1'b0, 1'b1);
    tRdWr(1'b1, 1'b1, 1'b1);
    tRdWr(1'b1, 1'b0, 1'b0);
    tPrecharge(1'b0);
    tPrecharge(1'b1);
    tMrs();
    tRefreshNop();
    tOddEncodings();
    tPulse();
    tDeselect();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule